// File: doc/BRIEF.md
# One-Time-Programmable Fuse Memory

This block models a read-only memory whose bits are set by blowing fuses. Every cell starts at a blank level. A program strobe moves one addressed cell to the opposite level, and that change is permanent. Reads are combinational. The word at the read address appears on the data output at once. An output-enable signal, decoded from the chip-select pins, tells the surrounding logic whether the data pins would be driven or left floating.

Parameters set the word count, the data width, the blank polarity and the chip-select scheme. There are three select schemes. In the first, one active-low select controls the outputs and the second pin is ignored. In the second, two active-low selects must both be low. In the third, two active-high selects must both be high. Programming is allowed only while the outputs are disabled. A strobe that arrives while the outputs are enabled is refused and raises an error flag. Ordinary reset leaves the fuse contents untouched. A dedicated initialization input, used only by test benches, restores the blank pattern.

Top module: `otp_fuse_rom`

## Requirements
- R1: While `fuse_init` is high at a clock edge, every word returns to the blank pattern. The blank pattern is all zeros when `BLANK_HIGH`=0 and all ones when `BLANK_HIGH`=1. It is readable right after that edge and wins over a simultaneous program strobe.
- R2: A strobe with the outputs disabled, an address below `WORDS` and a bit index below `WIDTH` sets that one bit to the programmed level at the clock edge. The programmed level is the inverse of the blank level. The new value is readable right after that edge.
- R3: A programmed bit never returns to its blank level except through `fuse_init`. Strobing an already programmed bit again changes nothing.
- R4: A single program operation changes at most one bit of the memory.
- R5: With `SEL_MODE`=SEL_ONE_LOW, `rd_oe` is 1 exactly when `sel_a` is 0, whatever the value of `sel_b`.
- R6: With `SEL_MODE`=SEL_TWO_LOW, `rd_oe` is 1 exactly when `sel_a` and `sel_b` are both 0.
- R7: With `SEL_MODE`=SEL_TWO_HIGH, `rd_oe` is 1 exactly when `sel_a` and `sel_b` are both 1.
- R8: A strobe while `rd_oe` is 1 changes no bit. `pgm_err` is 1 in the cycle after such a strobe and 0 after every other cycle. `pgm_err` is 0 from reset.
- R9: A strobe whose bit index is `WIDTH` or more changes no bit and does not raise `pgm_err`.
- R10: Asserting `rst` clears `pgm_err` only. The stored contents survive it.
- R11: With `BLANK_HIGH`=1, blank bits read 1 and programming drives a bit to 0.
- R12: `rd_data` always shows the word at `rd_addr`, whether `rd_oe` is 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the error flag |
| fuse_init | input | 1 | Restores every cell to the blank level (test use) |
| rd_addr | input | AW | Read word address |
| sel_a | input | 1 | First chip select |
| sel_b | input | 1 | Second chip select |
| rd_data | output | WIDTH | Word at `rd_addr` |
| rd_oe | output | 1 | Output enable decoded from the selects |
| pgm_addr | input | AW | Word to program |
| pgm_bit | input | BW | Bit index to program (one spare bit for out-of-range values) |
| pgm_strobe | input | 1 | Program request, sampled at the clock edge |
| pgm_err | output | 1 | Request refused because the outputs were enabled |

## Verification
The bench programs two distinct bit positions in every word of a 32x8 blank-low memory. It then sweeps all words, so that a wrong address decode, a wrong bit position or a neighbouring bit being disturbed each shows as a mismatched word. Repeating the first pattern exposes any toggle or clear behaviour. Strobes with the outputs enabled and strobes with indices past the width separate the refusal path from the range check. A 16x4 blank-high instance repeats the sweep with inverted polarity. All four select combinations are applied to all three select schemes. A reset in mid-run followed by a full sweep separates ordinary reset from fuse initialization.

// File: rtl/otp_pkg.sv
package otp_pkg;
  typedef enum logic [1:0] {
    SEL_ONE_LOW  = 2'd0,
    SEL_TWO_LOW  = 2'd1,
    SEL_TWO_HIGH = 2'd2
  } sel_mode_e;
endpackage

// File: rtl/otp_sel_decode.sv
module otp_sel_decode #(
  parameter otp_pkg::sel_mode_e SEL_MODE = otp_pkg::SEL_ONE_LOW
) (
  input  logic sel_a,
  input  logic sel_b,
  output logic oe
);
  logic one_low, both_low, both_high;

  assign one_low   = ~sel_a;
  assign both_low  = ~sel_a & ~sel_b;
  assign both_high = sel_a & sel_b;

  always_comb begin
    case (SEL_MODE)
      otp_pkg::SEL_TWO_LOW:  oe = both_low;
      otp_pkg::SEL_TWO_HIGH: oe = both_high;
      default:               oe = one_low;
    endcase
  end
endmodule

// File: rtl/otp_pgm_ctrl.sv
module otp_pgm_ctrl #(
  parameter int WORDS = 32,
  parameter int WIDTH = 8,
  parameter int AW    = 5,
  parameter int LBW   = 3,
  parameter int BW    = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           strobe,
  input  logic [AW-1:0]  addr,
  input  logic [BW-1:0]  bit_idx,
  input  logic           oe,
  output logic           we,
  output logic [LBW-1:0] wbit,
  output logic           err
);
  localparam logic [AW:0]   WORDS_V = (AW+1)'(WORDS);
  localparam logic [BW-1:0] WIDTH_V = BW'(WIDTH);

  logic addr_ok, bit_ok;

  assign addr_ok = {1'b0, addr} < WORDS_V;
  assign bit_ok  = bit_idx < WIDTH_V;
  assign we      = strobe & ~oe & addr_ok & bit_ok;
  assign wbit    = bit_idx[LBW-1:0];

  // Refusal flag: one cycle after each strobe taken while outputs enabled
  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else     err <= strobe & oe;
  end
endmodule

// File: rtl/otp_fuse_array.sv
module otp_fuse_array #(
  parameter int WORDS      = 32,
  parameter int WIDTH      = 8,
  parameter bit BLANK_HIGH = 1'b0,
  parameter int AW         = 5,
  parameter int LBW        = 3
) (
  input  logic             clk,
  input  logic             init,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [LBW-1:0]   wbit,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  localparam logic             BLANK      = BLANK_HIGH;
  localparam logic             PROGRAMMED = ~BLANK_HIGH;
  localparam logic [WIDTH-1:0] BLANK_WORD = {WIDTH{BLANK}};
  localparam logic [AW:0]      WORDS_V    = (AW+1)'(WORDS);

  logic [WIDTH-1:0] cells [WORDS];

  // Only the programmed level is ever written, so a fuse cannot heal
  always_ff @(posedge clk) begin
    if (init) begin
      for (int w = 0; w < WORDS; w++) cells[w] <= BLANK_WORD;
    end else if (we) begin
      cells[waddr][wbit] <= PROGRAMMED;
    end
  end

  assign rdata = ({1'b0, raddr} < WORDS_V) ? cells[raddr] : BLANK_WORD;
endmodule

// File: rtl/otp_fuse_rom.sv
module otp_fuse_rom #(
  parameter int                 WORDS      = 32,
  parameter int                 WIDTH      = 8,
  parameter bit                 BLANK_HIGH = 1'b0,
  parameter otp_pkg::sel_mode_e SEL_MODE   = otp_pkg::SEL_ONE_LOW,
  localparam int AW  = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int LBW = (WIDTH > 1) ? $clog2(WIDTH) : 1,
  localparam int BW  = LBW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fuse_init,
  input  logic [AW-1:0]    rd_addr,
  input  logic             sel_a,
  input  logic             sel_b,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_oe,
  input  logic [AW-1:0]    pgm_addr,
  input  logic [BW-1:0]    pgm_bit,
  input  logic             pgm_strobe,
  output logic             pgm_err
);
  logic           wr_en;
  logic [LBW-1:0] wr_bit;

  otp_sel_decode #(.SEL_MODE(SEL_MODE)) u_sel (
    .sel_a (sel_a),
    .sel_b (sel_b),
    .oe    (rd_oe)
  );

  otp_pgm_ctrl #(
    .WORDS(WORDS), .WIDTH(WIDTH), .AW(AW), .LBW(LBW), .BW(BW)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .strobe  (pgm_strobe),
    .addr    (pgm_addr),
    .bit_idx (pgm_bit),
    .oe      (rd_oe),
    .we      (wr_en),
    .wbit    (wr_bit),
    .err     (pgm_err)
  );

  otp_fuse_array #(
    .WORDS(WORDS), .WIDTH(WIDTH), .BLANK_HIGH(BLANK_HIGH), .AW(AW), .LBW(LBW)
  ) u_array (
    .clk   (clk),
    .init  (fuse_init),
    .we    (wr_en),
    .waddr (pgm_addr),
    .wbit  (wr_bit),
    .raddr (rd_addr),
    .rdata (rd_data)
  );
endmodule

// File: rtl/otp_fuse_rom_chk.sv
module otp_fuse_rom_chk #(
  parameter int WORDS      = 32,
  parameter int WIDTH      = 8,
  parameter bit BLANK_HIGH = 1'b0,
  localparam int AW  = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int LBW = (WIDTH > 1) ? $clog2(WIDTH) : 1,
  localparam int BW  = LBW + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             fuse_init,
  input logic [AW-1:0]    rd_addr,
  input logic [WIDTH-1:0] rd_data,
  input logic             rd_oe,
  input logic [BW-1:0]    pgm_bit,
  input logic             pgm_strobe,
  input logic             pgm_err
);
  localparam logic [WIDTH-1:0] BLANK_WORD = {WIDTH{BLANK_HIGH}};
  localparam logic [BW-1:0]    WIDTH_V    = BW'(WIDTH);

  logic [WIDTH-1:0] burnt;
  assign burnt = BLANK_HIGH ? ~rd_data : rd_data;

  assert_blank_after_init_R1: assert property (@(posedge clk) disable iff (rst)
    $past(fuse_init) |-> (rd_data == BLANK_WORD));

  assert_no_heal_R3: assert property (@(posedge clk) disable iff (rst)
    ($stable(rd_addr) && !$past(fuse_init)) |-> (($past(burnt) & ~burnt) == '0));

  assert_one_bit_R4: assert property (@(posedge clk) disable iff (rst)
    ($stable(rd_addr) && !$past(fuse_init)) |-> ($countones(rd_data ^ $past(rd_data)) <= 1));

  assert_err_raise_R8: assert property (@(posedge clk) disable iff (rst)
    (pgm_strobe && rd_oe) |=> pgm_err);

  assert_err_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !(pgm_strobe && rd_oe) |=> !pgm_err);

  assert_locked_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(pgm_strobe && rd_oe) && $stable(rd_addr) && !$past(fuse_init)) |-> $stable(rd_data));

  assert_range_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(pgm_strobe && (pgm_bit >= WIDTH_V)) && $stable(rd_addr) && !$past(fuse_init))
      |-> $stable(rd_data));
endmodule

bind otp_fuse_rom otp_fuse_rom_chk #(
  .WORDS(WORDS), .WIDTH(WIDTH), .BLANK_HIGH(BLANK_HIGH)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .fuse_init  (fuse_init),
  .rd_addr    (rd_addr),
  .rd_data    (rd_data),
  .rd_oe      (rd_oe),
  .pgm_bit    (pgm_bit),
  .pgm_strobe (pgm_strobe),
  .pgm_err    (pgm_err)
);

// File: tb/test_otp_fuse_rom.sv
`timescale 1ns/1ps
module test_otp_fuse_rom;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, init, sel_a, sel_b;
  logic [4:0] ra_addr, pa_addr;
  logic [3:0] pa_bit;
  logic       stb_a;
  logic [7:0] da;
  logic       oe_a, err_a;
  logic [3:0] rb_addr, pb_addr;
  logic [2:0] pb_bit;
  logic       stb_b;
  logic [3:0] db;
  logic       oe_b, err_b;
  logic [3:0] dc;
  logic       oe_c, err_c;

  int nchk = 0, nerr = 0;
  bit done = 1'b0;
  logic [7:0] ea [32];
  logic [3:0] eb [16];

  otp_fuse_rom #(.WORDS(32), .WIDTH(8), .BLANK_HIGH(1'b0), .SEL_MODE(otp_pkg::SEL_ONE_LOW)) i_otp_fuse_rom (
    .clk(clk), .rst(rst), .fuse_init(init), .rd_addr(ra_addr), .sel_a(sel_a), .sel_b(sel_b),
    .rd_data(da), .rd_oe(oe_a), .pgm_addr(pa_addr), .pgm_bit(pa_bit), .pgm_strobe(stb_a), .pgm_err(err_a));

  otp_fuse_rom #(.WORDS(16), .WIDTH(4), .BLANK_HIGH(1'b1), .SEL_MODE(otp_pkg::SEL_TWO_HIGH)) i_otp_fuse_rom_hi (
    .clk(clk), .rst(rst), .fuse_init(init), .rd_addr(rb_addr), .sel_a(sel_a), .sel_b(sel_b),
    .rd_data(db), .rd_oe(oe_b), .pgm_addr(pb_addr), .pgm_bit(pb_bit), .pgm_strobe(stb_b), .pgm_err(err_b));

  otp_fuse_rom #(.WORDS(8), .WIDTH(4), .BLANK_HIGH(1'b0), .SEL_MODE(otp_pkg::SEL_TWO_LOW)) i_otp_fuse_rom_lo (
    .clk(clk), .rst(rst), .fuse_init(init), .rd_addr(3'd0), .sel_a(sel_a), .sel_b(sel_b),
    .rd_data(dc), .rd_oe(oe_c), .pgm_addr(3'd0), .pgm_bit(3'd0), .pgm_strobe(1'b0), .pgm_err(err_c));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_a(input logic [4:0] a, input logic [3:0] b);
    @(negedge clk); pa_addr = a; pa_bit = b; stb_a = 1'b1;
    @(negedge clk); stb_a = 1'b0;
  endtask

  task automatic pulse_b(input logic [3:0] a, input logic [2:0] b);
    @(negedge clk); pb_addr = a; pb_bit = b; stb_b = 1'b1;
    @(negedge clk); stb_b = 1'b0;
  endtask

  task automatic sweep(input string tag);
    for (int w = 0; w < 32; w++) begin ra_addr = 5'(w); #1; chk(tag, {24'd0, da}, {24'd0, ea[w]}); end
    for (int w = 0; w < 16; w++) begin rb_addr = 4'(w); #1; chk(tag, {28'd0, db}, {28'd0, eb[w]}); end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired (all requirements)");
    summary();
  end

  initial begin
    rst = 1'b1; init = 1'b1; sel_a = 1'b1; sel_b = 1'b0;
    ra_addr = '0; pa_addr = '0; pa_bit = '0; stb_a = 1'b0;
    rb_addr = '0; pb_addr = '0; pb_bit = '0; stb_b = 1'b0;
    for (int w = 0; w < 32; w++) ea[w] = 8'h00;
    for (int w = 0; w < 16; w++) eb[w] = 4'hF;
    repeat (3) @(negedge clk);
    rst = 1'b0; init = 1'b0;
    #1;
    chk("R8 reset err", {31'd0, err_a}, 32'd0);
    sweep("R1 blank");                       // also R11 blank-high reads ones

    // R2/R4: two distinct bits per word, A outputs disabled (sel_a=1)
    for (int w = 0; w < 32; w++) begin
      pulse_a(5'(w), 4'((w * 3) % 8));
      ea[w][(w * 3) % 8] = 1'b1;
      ra_addr = 5'(w); #1;
      chk("R2 program", {24'd0, da}, {24'd0, ea[w]});
      pulse_a(5'(w), 4'((w + 5) % 8));
      ea[w][(w + 5) % 8] = 1'b1;
      #1;
      chk("R4 single bit", {24'd0, da}, {24'd0, ea[w]});
    end
    sweep("R2 sweep");

    // R3: repeat the first pattern, nothing changes
    for (int w = 0; w < 32; w++) pulse_a(5'(w), 4'((w * 3) % 8));
    sweep("R3 repeat");

    // R12: data independent of output enable
    sel_a = 1'b0; sel_b = 1'b0; #1;
    chk("R5 enabled", {31'd0, oe_a}, 32'd1);
    for (int w = 0; w < 32; w++) begin ra_addr = 5'(w); #1; chk("R12 oe on", {24'd0, da}, {24'd0, ea[w]}); end

    // R8: strobe with outputs enabled is refused and flagged
    pulse_a(5'd1, 4'd0);
    ra_addr = 5'd1; #1;
    chk("R8 err raised", {31'd0, err_a}, 32'd1);
    chk("R8 word kept", {24'd0, da}, {24'd0, ea[1]});
    @(negedge clk);
    chk("R8 err cleared", {31'd0, err_a}, 32'd0);

    // R9: out-of-range bit indices, outputs disabled
    sel_a = 1'b1;
    for (int b = 8; b < 16; b++) begin
      pulse_a(5'd2, 4'(b));
      ra_addr = 5'd2; #1;
      chk("R9 ignored", {24'd0, da}, {24'd0, ea[2]});
      chk("R9 no err", {31'd0, err_a}, 32'd0);
    end

    // R5/R6/R7: all select combinations
    for (int s = 0; s < 4; s++) begin
      sel_a = s[1]; sel_b = s[0]; #1;
      chk("R5 one-low", {31'd0, oe_a}, {31'd0, ~s[1]});
      chk("R6 two-low", {31'd0, oe_c}, {31'd0, (s == 0)});
      chk("R7 two-high", {31'd0, oe_b}, {31'd0, (s == 3)});
    end

    // R11: blank-high instance, disabled with sel_a=1 sel_b=0
    sel_a = 1'b1; sel_b = 1'b0;
    for (int w = 0; w < 16; w++) begin
      pulse_b(4'(w), 3'(w % 4));
      eb[w][w % 4] = 1'b0;
      if (w >= 8) begin
        pulse_b(4'(w), 3'((w + 1) % 4));
        eb[w][(w + 1) % 4] = 1'b0;
      end
      rb_addr = 4'(w); #1;
      chk("R11 clear", {28'd0, db}, {28'd0, eb[w]});
    end
    pulse_b(4'd3, 3'd5);
    rb_addr = 4'd3; #1;
    chk("R9 ignored hi", {28'd0, db}, {28'd0, eb[3]});

    // R10: reset leaves contents
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    #1;
    chk("R10 err", {31'd0, err_a}, 32'd0);
    sweep("R10 kept");

    // R1: initialization restores blank, wins over a strobe in the same cycle
    @(negedge clk); init = 1'b1; pa_addr = 5'd4; pa_bit = 4'd0; stb_a = 1'b1;
    @(negedge clk); init = 1'b0; stb_a = 1'b0;
    for (int w = 0; w < 32; w++) ea[w] = 8'h00;
    for (int w = 0; w < 16; w++) eb[w] = 4'hF;
    sweep("R1 reinit");

    summary();
  end
endmodule